// File: doc/BRIEF.md
# PCI configuration address translator

This block sits in a PCI host bridge and owns the register through which the host names the target of a configuration access. Software writes one 32-bit word in which the target device is picked by setting a single bit at or above bit 11. The block finds the lowest such bit and stores a conventional configuration address. That address carries an enable bit, bus 0, a five-bit device number, a three-bit function and a register offset. Downstream configuration logic reads the stored address and a valid flag from the block's outputs. A host read of the same port rebuilds the one-hot form from the stored address.

The host bus is a plain 32-bit single-cycle write/read strobe interface. The address port and the configuration data port each decode their own 4 KB window. For the data port the block only produces a registered select pulse. A parameter selects a big-endian host, in which case every word is byte-swapped on the way in and on the way out. The block also folds per-device interrupt pins onto four shared lines: pin p of device d drives line (p + d) mod 4. The four lines land on a wider interrupt-controller input vector at a parameterised base position, 8 by default.

Top module: `cfg_addr_xlat`

## Requirements
- R1: After reset, cfg_addr is zero, cfg_valid is 0, bus_rvalid and data_sel are 0, and intc_out is zero.
- R2: A write to the address window stores bit 31 = 1, bits 30:17 = 0 and bits 1:0 = 0. Bits 10:2 are copied from the (endian-corrected) written word, and bits 16:11 hold the index of the lowest set bit in word bits 31:11. The result is visible on cfg_addr the cycle after the write.
- R3: When word bits 31:11 are all zero, the index stored at bits 16:11 is 32. Bit 16 is then 1 and bits 15:11 are 0.
- R4: cfg_valid is 1 after a write that found a set select bit and 0 after a write that found none.
- R5: A read of the address window returns, one cycle later with bus_rvalid high, 1 shifted left by cfg_addr[15:11], OR'd with cfg_addr[10:8] at bits 10:8 and cfg_addr[7:2] at bits 7:2.
- R6: With BIG_ENDIAN = 1 the written word is byte-reversed before translation and the read word is byte-reversed before it is returned.
- R7: Accesses outside the address window leave cfg_addr and cfg_valid unchanged and raise no bus_rvalid. An access to the data window raises data_sel for exactly one cycle, one cycle later.
- R8: Shared line k is high one cycle after some input dev_int[4*d + p] is high with (p + d) mod 4 = k, and low otherwise.
- R9: The four shared lines appear on intc_out[IRQ_BASE+3:IRQ_BASE] (bits 11:8 by default), and every other intc_out bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Host access address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Host write word |
| bus_rdata | output | 32 | Read word, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| data_sel | output | 1 | Registered pulse for a data-window access |
| cfg_addr | output | 32 | Stored configuration address |
| cfg_valid | output | 1 | Stored address names a real device |
| dev_int | input | 128 | Interrupt pins, four per device, device-major |
| intc_out | output | 16 | Interrupt-controller input vector |

## Verification
The hardest case to reach is a write whose select field is entirely empty, since random words almost always carry some high bit. Such a write stores index 32, which spills into bit 16, and its readback degenerates to bit 0. The stimulus therefore masks random words with random high-bit clear masks, so that the lowest set bit lands at every position from 11 to 31. It also issues directed all-zero-select, bit-11-only and bit-31-only words. A second instance with the big-endian setting shares the same stimulus, which exposes byte-lane mistakes in either direction.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;
  localparam int WORD_W   = 32;
  localparam int SEL_LO   = 11;
  localparam int PINS     = 4;
  localparam int WIN_BITS = 12;
  localparam int IDX_W    = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_ADDR = 2'd1,
    ACC_DATA = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/cfg_bswap.sv
module cfg_bswap #(
  parameter int W      = 32,
  parameter bit ENABLE = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;
  generate
    if (ENABLE) begin : g_swap
      for (genvar b = 0; b < NB; b++) begin : g_byte
        assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
      end
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/cfg_sel_scan.sv
module cfg_sel_scan #(
  parameter int W  = 32,
  parameter int LO = 11,
  parameter int IW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = IW'(W);
    found = 1'b0;
    for (int i = W - 1; i >= LO; i--) begin
      if (word[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_irq_router.sv
module cfg_irq_router #(
  parameter int NUM_DEV = 32,
  parameter int PINS    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_DEV*PINS-1:0] dev_int,
  output logic [PINS-1:0]         lines
);
  logic [PINS-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int p = 0; p < PINS; p++) begin
        if (dev_int[d*PINS + p]) nxt[(p + d) % PINS] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lines <= '0;
    else     lines <= nxt;
  end

  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (dev_int == '0) |=> (lines == '0));
  assert_line0_R8: assert property (@(posedge clk) disable iff (rst)
    dev_int[0] |=> lines[0]);
endmodule

// File: rtl/cfg_addr_xlat.sv
module cfg_addr_xlat
  import cfg_xlat_pkg::*;
#(
  parameter logic [31:0] ADDR_BASE  = 32'hF280_0000,
  parameter logic [31:0] DATA_BASE  = 32'hF2C0_0000,
  parameter bit          BIG_ENDIAN = 1'b0,
  parameter int          NUM_DEV    = 32,
  parameter int          INTC_W     = 16,
  parameter int          IRQ_BASE   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [31:0]             bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_rvalid,
  output logic                    data_sel,
  output logic [31:0]             cfg_addr,
  output logic                    cfg_valid,
  input  logic [NUM_DEV*PINS-1:0] dev_int,
  output logic [INTC_W-1:0]       intc_out
);
  localparam int PAGE_W = WORD_W - WIN_BITS;

  acc_kind_t          kind;
  logic [WORD_W-1:0]  wword, rword_le, rword;
  logic [IDX_W-1:0]   idx;
  logic               found;
  logic [PINS-1:0]    lines;

  always_comb begin
    kind = ACC_NONE;
    if (bus_addr[WORD_W-1:WIN_BITS] == ADDR_BASE[WORD_W-1:WIN_BITS])
      kind = ACC_ADDR;
    else if (bus_addr[WORD_W-1:WIN_BITS] == DATA_BASE[WORD_W-1:WIN_BITS])
      kind = ACC_DATA;
  end

  cfg_bswap #(.W(WORD_W), .ENABLE(BIG_ENDIAN)) u_swap_in (
    .din(bus_wdata), .dout(wword));

  cfg_sel_scan #(.W(WORD_W), .LO(SEL_LO), .IW(IDX_W)) u_scan (
    .word(wword), .idx(idx), .found(found));

  wire wr_hit = bus_wr && (kind == ACC_ADDR);
  wire rd_hit = bus_rd && (kind == ACC_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_addr  <= '0;
      cfg_valid <= 1'b0;
    end else if (wr_hit) begin
      cfg_addr  <= 32'h8000_0000 | (wword & 32'h0000_07FC)
                 | (32'(idx) << SEL_LO);
      cfg_valid <= found;
    end
  end

  always_comb begin
    rword_le = (32'd1 << cfg_addr[15:11])
             | {21'd0, cfg_addr[10:8], 8'd0}
             | {24'd0, cfg_addr[7:2], 2'd0};
  end

  cfg_bswap #(.W(WORD_W), .ENABLE(BIG_ENDIAN)) u_swap_out (
    .din(rword_le), .dout(rword));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      data_sel   <= 1'b0;
    end else begin
      bus_rvalid <= rd_hit;
      data_sel   <= (bus_wr || bus_rd) && (kind == ACC_DATA);
      if (rd_hit) bus_rdata <= rword;
    end
  end

  cfg_irq_router #(.NUM_DEV(NUM_DEV), .PINS(PINS)) u_irq (
    .clk(clk), .rst(rst), .dev_int(dev_int), .lines(lines));

  always_comb begin
    intc_out = '0;
    intc_out[IRQ_BASE +: PINS] = lines;
  end

  assert_enable_R2: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (cfg_addr[31] && cfg_addr[30:17] == '0 && cfg_addr[1:0] == 2'b00));
  assert_empty_sel_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr[31] && !cfg_valid) |-> (cfg_addr[16] && cfg_addr[15:11] == '0));
  assert_valid_bus0_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (cfg_addr[31] && !cfg_addr[16] && cfg_addr[15:11] >= 5'(SEL_LO)));
  assert_rvalid_R5: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> bus_rvalid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> ($stable(cfg_addr) && $stable(cfg_valid)));
  assert_datasel_R7: assert property (@(posedge clk) disable iff (rst)
    (kind != ACC_DATA) |=> !data_sel);

  logic [PAGE_W-1:0] unused_page;
  assign unused_page = PAGE_W'(0);
endmodule

// File: tb/test_cfg_addr_xlat.sv
module test_cfg_addr_xlat;
  localparam logic [31:0] ABASE = 32'hF280_0000;
  localparam logic [31:0] DBASE = 32'hF2C0_0000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  bus_addr = '0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [127:0] dev_int = '0;
  logic [31:0]  rdata, rdata_be, cfg, cfg_be;
  logic         rvalid, rvalid_be, dsel, dsel_be, valid, valid_be;
  logic [15:0]  intc, intc_be;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_addr_xlat i_cfg_addr_xlat (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .bus_rvalid(rvalid), .data_sel(dsel),
    .cfg_addr(cfg), .cfg_valid(valid), .dev_int(dev_int), .intc_out(intc));

  cfg_addr_xlat #(.BIG_ENDIAN(1'b1)) i_cfg_addr_xlat_be (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_be), .bus_rvalid(rvalid_be),
    .data_sel(dsel_be), .cfg_addr(cfg_be), .cfg_valid(valid_be),
    .dev_int(dev_int), .intc_out(intc_be));

  function automatic logic [31:0] swap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] exp_store(input logic [31:0] v);
    int k = 32;
    for (int i = 31; i >= 11; i--) if (v[i]) k = i;
    return 32'h8000_0000 | (v & 32'h7FC) | (32'(k) << 11);
  endfunction

  function automatic logic exp_found(input logic [31:0] v);
    return v[31:11] != '0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] s);
    int dev = int'(s[15:11]);
    return (32'd1 << dev) | (s & 32'h7FC);
  endfunction

  function automatic logic [3:0] exp_lines(input logic [127:0] d);
    logic [3:0] r = '0;
    for (int dv = 0; dv < 32; dv++)
      for (int p = 0; p < 4; p++)
        if (d[dv*4 + p]) r[(p + dv) % 4] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic r,
                        input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr_check(input logic [31:0] v);
    logic [31:0] s  = exp_store(v);
    logic [31:0] sb = exp_store(swap(v));
    access(ABASE | 32'h10, 1, 0, v);
    chk("R2", cfg, s);
    chk("R4", valid, exp_found(v));
    chk("R6 store", cfg_be, sb);
    chk("R6 valid", valid_be, exp_found(swap(v)));
    access(ABASE, 0, 1, 32'h0);
    chk("R5 rvalid", rvalid, 1);
    chk("R5", rdata, exp_read(s));
    chk("R6 read", rdata_be, swap(exp_read(sb)));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 cfg", cfg, 0);
    chk("R1 valid", valid, 0);
    chk("R1 rvalid", rvalid, 0);
    chk("R1 dsel", dsel, 0);
    chk("R1 intc", intc, 0);

    // directed corners
    wr_check(32'h0000_0800);          // device 11, host bridge slot
    wr_check(32'h8000_0000);          // device 31
    wr_check(32'h0000_0704);          // R3: no select bit
    chk("R3 index", cfg[16:11], 6'd32);
    chk("R3 valid", valid, 0);
    wr_check(32'h0001_FFFF);
    wr_check(32'hFFFF_F800);

    // R7: other windows ignored
    access(DBASE | 32'h4, 1, 0, 32'h0010_0000);
    chk("R7 hold", cfg, exp_store(32'hFFFF_F800));
    chk("R7 dsel", dsel, 1);
    @(negedge clk);
    chk("R7 dsel one", dsel, 0);
    access(32'h1000_0000, 1, 1, 32'h0000_1000);
    chk("R7 other", cfg, exp_store(32'hFFFF_F800));
    chk("R7 rvalid", rvalid, 0);

    // random writes with random high-bit masks
    for (int n = 0; n < 200; n++) begin
      logic [31:0] v = $urandom();
      int sh = $urandom_range(0, 21);
      v = v & ~(((32'd1 << sh) - 1) << 11);
      wr_check(v);
    end

    // interrupt routing
    for (int n = 0; n < 60; n++) begin
      logic [127:0] d;
      if (n < 16) d = 128'd1 << (n * 5);
      else d = {$urandom(), $urandom(), $urandom(), $urandom()} &
               {4{$urandom()}} & {4{$urandom()}};
      @(negedge clk);
      dev_int = d;
      @(negedge clk);
      chk("R8", intc[11:8], exp_lines(d));
      chk("R9", {intc[15:12], intc[7:0]}, 12'd0);
    end
    dev_int = '0;
    @(negedge clk); @(negedge clk);
    chk("R8 idle", intc, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule